// File: doc/BRIEF.md
# Serial Cyclic Block Code Encoder and Syndrome Checker

This block encodes and checks fixed-length binary cyclic block codes one bit at a time. It uses a single shift-register divider whose feedback taps come from the selected generator polynomial. Two code families are supported. The first is the (23,12) Golay code, which has a minimum distance of 7 and a choice of two degree-11 generators. The second is the cyclic (31,26) Hamming code, whose generator is 1+X^2+X^5. Every valid codeword is a multiple of its generator, and any cyclic rotation of a valid codeword is also valid.

An operation starts with a one-cycle start pulse while the block is idle. The code selection and the operation type (encode or check) are captured at that point and held until the operation ends.

In encode mode, the k message bits are fed in serially, highest-degree bit first. The block echoes each accepted bit on its serial output. After the last message bit it emits the n−k parity bits in back-to-back cycles. The parity bits are the remainder of X^(n−k)·D(X) divided by g(X), so the codeword is systematic.

In check mode, all n received bits are fed through the same divider. The remainder is then presented as the syndrome, together with a flag that is set when the syndrome is non-zero. Locating or correcting errors is left to the logic that consumes the syndrome.

Top module: `cyc_code_lfsr`

## Requirements
- R1: The selector `code_sel` chooses the code. The value 00 selects the Golay (23,12) code with generator 1+X^2+X^4+X^5+X^6+X^10+X^11. The value 01 selects the Golay (23,12) code with generator 1+X+X^5+X^6+X^7+X^9+X^11. The values 10 and 11 both select the Hamming (31,26) code with generator 1+X^2+X^5.
- R2: A start pulse is taken only while `busy` is low. It captures `code_sel` and `check_mode`. Start pulses and changes of `code_sel` while `busy` is high have no effect on the running operation.
- R3: In encode mode, each message bit accepted with `in_valid` appears on `out_bit` with `out_valid` high exactly one cycle later. Message bits keep their order, and the first bit fed is the coefficient of X^(n−1).
- R4: After the k-th message bit, the n−k parity bits follow in consecutive cycles with no gap. They are the remainder of X^(n−k)·D(X) mod g(X), with the highest-degree bit first. The output therefore carries exactly n bits per encode.
- R5: `in_valid` is ignored while the block is idle, during the parity phase and during the finishing cycle. In those states it produces no output and leaves the result unchanged.
- R6: In check mode, after n accepted bits, `syndrome` holds the remainder of the received polynomial mod g(X), and `syn_nonzero` is high exactly when that remainder is non-zero. Both are valid in the `done` cycle and hold until the next check completes. Check mode produces no `out_valid`.
- R7: `busy` rises on the cycle after an accepted start. `done` is high for one cycle at the end of an operation, and `busy` falls on the following cycle.
- R8: A valid codeword, or any cyclic rotation of it, gives a zero syndrome. Any error pattern of weight 1 to 6 on a Golay codeword, and any single-bit error on a Hamming codeword, gives a non-zero syndrome.
- R9: After reset, `busy`, `out_valid`, `done`, `syndrome` and `syn_nonzero` are all zero.
- R10: Cycles in the message phase with `in_valid` low stall the operation without changing its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_sel | input | 2 | Code and generator selection, captured at start |
| check_mode | input | 1 | 0 = encode, 1 = syndrome check; captured at start |
| start | input | 1 | Begin an operation (taken only when idle) |
| in_valid | input | 1 | Serial input bit is valid this cycle |
| in_bit | input | 1 | Serial input bit, highest degree first |
| busy | output | 1 | Operation in progress |
| out_valid | output | 1 | Encoded output bit valid |
| out_bit | output | 1 | Encoded codeword bit |
| done | output | 1 | One-cycle end-of-operation pulse |
| syndrome | output | 11 | Remainder of the last checked word (low n−k bits used) |
| syn_nonzero | output | 1 | Last checked syndrome is non-zero |

## Verification
Two events share a cycle at the end of every encode: the last parity bit appears on the output in the same cycle that `done` pulses. The bench also pushes stray `start` pulses, junk `in_valid` and random `code_sel` changes into that closing cycle and into the parity phase. Each case is judged in two ways. The full n-bit stream collected from the output must equal a long-division model. The operation that follows must start cleanly, with `busy` returning low exactly one cycle after `done`. Random gaps in the message phase stress the interaction between stalls and the final-bit transition.

// File: rtl/cyc_code_pkg.sv
package cyc_code_pkg;

    localparam int unsigned R_MAX = 11;
    localparam int unsigned N_MAX = 31;
    localparam int unsigned RW    = $clog2(R_MAX + 1);
    localparam int unsigned NW    = $clog2(N_MAX + 1);

    typedef enum logic [1:0] {
        CODE_GOLAY_A = 2'b00,
        CODE_GOLAY_B = 2'b01,
        CODE_HAM_A   = 2'b10,
        CODE_HAM_B   = 2'b11
    } code_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_PARITY,
        PH_FINISH
    } phase_e;

    // Generator description: low coefficients (X^r term implied), degree, length
    typedef struct packed {
        logic [R_MAX-1:0] taps;
        logic [RW-1:0]    deg;
        logic [NW-1:0]    len;
    } code_desc_t;

    function automatic code_desc_t describe(input code_sel_e sel);
        code_desc_t d;
        case (sel)
            CODE_GOLAY_A: begin
                d.taps = R_MAX'(11'h475);
                d.deg  = RW'(11);
                d.len  = NW'(23);
            end
            CODE_GOLAY_B: begin
                d.taps = R_MAX'(11'h2E3);
                d.deg  = RW'(11);
                d.len  = NW'(23);
            end
            default: begin
                d.taps = R_MAX'(11'h005);
                d.deg  = RW'(5);
                d.len  = NW'(31);
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cyc_code_ctrl.sv
module cyc_code_ctrl
    import cyc_code_pkg::*;
#(
    parameter int unsigned NW_P = NW,
    parameter int unsigned RW_P = RW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [1:0]   sel_i,
    input  logic         check_i,
    input  logic         bit_valid_i,
    output phase_e       phase_o,
    output code_desc_t   desc_o,
    output logic         check_o,
    output logic         accept_o,
    output logic         par_shift_o,
    output logic         clear_o,
    output logic         last_in_o
);

    phase_e           phase_q;
    code_desc_t       desc_q;
    logic             check_q;
    logic [NW_P-1:0]  cnt_q;
    logic [NW_P-1:0]  in_len;
    logic             last_par;

    assign in_len      = check_q ? desc_q.len : desc_q.len - NW_P'(desc_q.deg);
    assign accept_o    = (phase_q == PH_LOAD) && bit_valid_i;
    assign last_in_o   = accept_o && (cnt_q == in_len - NW_P'(1));
    assign par_shift_o = (phase_q == PH_PARITY);
    assign last_par    = par_shift_o && (cnt_q == NW_P'(desc_q.deg) - NW_P'(1));
    assign clear_o     = (phase_q == PH_IDLE) && start_i;

    assign phase_o = phase_q;
    assign desc_o  = desc_q;
    assign check_o = check_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            desc_q  <= '0;
            check_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        desc_q  <= describe(code_sel_e'(sel_i));
                        check_q <= check_i;
                        cnt_q   <= '0;
                        phase_q <= PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    if (accept_o) begin
                        if (last_in_o) begin
                            cnt_q   <= '0;
                            phase_q <= check_q ? PH_FINISH : PH_PARITY;
                        end else begin
                            cnt_q <= cnt_q + NW_P'(1);
                        end
                    end
                end
                PH_PARITY: begin
                    if (last_par) begin
                        cnt_q   <= '0;
                        phase_q <= PH_FINISH;
                    end else begin
                        cnt_q <= cnt_q + NW_P'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cyc_code_divider.sv
module cyc_code_divider
    import cyc_code_pkg::*;
#(
    parameter int unsigned W  = R_MAX,
    parameter int unsigned DW = RW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          shift_i,
    input  logic          par_i,
    input  logic          premul_i,
    input  logic          bit_i,
    input  logic [W-1:0]  taps_i,
    input  logic [DW-1:0] deg_i,
    output logic [W-1:0]  next_o,
    output logic          msb_o
);

    logic [W-1:0] state_q;
    logic [W-1:0] top_sel;
    logic [W-1:0] nxt;
    logic         msb;
    logic         fb;
    logic         low_in;

    assign msb    = |(state_q & top_sel);
    assign fb     = par_i ? 1'b0 : (premul_i ? (bit_i ^ msb) : msb);
    assign low_in = (par_i || premul_i) ? 1'b0 : bit_i;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign top_sel[i] = (deg_i == DW'(i + 1));
        if (i == 0) begin : g_first
            assign nxt[i] = (DW'(i) < deg_i) & (low_in ^ (fb & taps_i[i]));
        end else begin : g_rest
            assign nxt[i] = (DW'(i) < deg_i) & (state_q[i-1] ^ (fb & taps_i[i]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            state_q <= '0;
        end else if (shift_i || par_i) begin
            state_q <= nxt;
        end
    end

    assign next_o = nxt;
    assign msb_o  = msb;

endmodule

// File: rtl/cyc_code_lfsr.sv
module cyc_code_lfsr
    import cyc_code_pkg::*;
#(
    parameter int unsigned SYN_W = R_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       code_sel,
    input  logic             check_mode,
    input  logic             start,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic             busy,
    output logic             out_valid,
    output logic             out_bit,
    output logic             done,
    output logic [SYN_W-1:0] syndrome,
    output logic             syn_nonzero
);

    phase_e           phase;
    code_desc_t       desc;
    logic             chk;
    logic             accept;
    logic             par_shift;
    logic             clear;
    logic             last_in;
    logic [R_MAX-1:0] div_next;
    logic             div_msb;

    logic             out_valid_q;
    logic             out_bit_q;
    logic [SYN_W-1:0] syn_q;
    logic             syn_nz_q;

    cyc_code_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .sel_i       (code_sel),
        .check_i     (check_mode),
        .bit_valid_i (in_valid),
        .phase_o     (phase),
        .desc_o      (desc),
        .check_o     (chk),
        .accept_o    (accept),
        .par_shift_o (par_shift),
        .clear_o     (clear),
        .last_in_o   (last_in)
    );

    cyc_code_divider u_div (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (clear),
        .shift_i  (accept),
        .par_i    (par_shift),
        .premul_i (~chk),
        .bit_i    (in_bit),
        .taps_i   (desc.taps),
        .deg_i    (desc.deg),
        .next_o   (div_next),
        .msb_o    (div_msb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_bit_q   <= 1'b0;
            syn_q       <= '0;
            syn_nz_q    <= 1'b0;
        end else begin
            out_valid_q <= (accept && !chk) || par_shift;
            out_bit_q   <= par_shift ? div_msb : in_bit;
            if (last_in && chk) begin
                syn_q    <= SYN_W'(div_next);
                syn_nz_q <= |div_next;
            end
        end
    end

    assign busy        = (phase != PH_IDLE);
    assign done        = (phase == PH_FINISH);
    assign out_valid   = out_valid_q;
    assign out_bit     = out_bit_q;
    assign syndrome    = syn_q;
    assign syn_nonzero = syn_nz_q;

endmodule

// File: rtl/cyc_code_lfsr_chk.sv
module cyc_code_lfsr_chk
    import cyc_code_pkg::*;
#(
    parameter int unsigned SYN_W = R_MAX
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       code_sel,
    input logic             check_mode,
    input logic             start,
    input logic             busy,
    input logic             out_valid,
    input logic             done,
    input logic [SYN_W-1:0] syndrome
);

    code_desc_t      seen_desc;
    logic            seen_chk;
    logic [NW-1:0]   ocnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_desc <= '0;
            seen_chk  <= 1'b0;
            ocnt      <= '0;
        end else if (start && !busy) begin
            seen_desc <= describe(code_sel_e'(code_sel));
            seen_chk  <= check_mode;
            ocnt      <= '0;
        end else if (out_valid) begin
            ocnt <= ocnt + NW'(1);
        end
    end

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_start_only_idle_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    p_out_inside_op_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);

    p_enc_length_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !seen_chk) |-> (out_valid && (ocnt == seen_desc.len - NW'(1))));

    p_check_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && seen_chk) |-> !out_valid);

    p_syn_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(syndrome));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

endmodule

bind cyc_code_lfsr cyc_code_lfsr_chk #(.SYN_W(SYN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .code_sel   (code_sel),
    .check_mode (check_mode),
    .start      (start),
    .busy       (busy),
    .out_valid  (out_valid),
    .done       (done),
    .syndrome   (syndrome)
);

// File: tb/cyc_code_lfsr_tb.sv
module cyc_code_lfsr_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  code_sel;
    logic        check_mode;
    logic        start;
    logic        in_valid;
    logic        in_bit;
    logic        busy;
    logic        out_valid;
    logic        out_bit;
    logic        done;
    logic [10:0] syndrome;
    logic        syn_nonzero;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cyc_code_lfsr dut_i (
        .clk         (clk),
        .rst         (rst),
        .code_sel    (code_sel),
        .check_mode  (check_mode),
        .start       (start),
        .in_valid    (in_valid),
        .in_bit      (in_bit),
        .busy        (busy),
        .out_valid   (out_valid),
        .out_bit     (out_bit),
        .done        (done),
        .syndrome    (syndrome),
        .syn_nonzero (syn_nonzero)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] gfull(input int m);
        case (m)
            0:       return 12'hC75;
            1:       return 12'hAE3;
            default: return 12'h025;
        endcase
    endfunction

    function automatic int r_of(input int m);
        return (m < 2) ? 11 : 5;
    endfunction

    function automatic int n_of(input int m);
        return (m < 2) ? 23 : 31;
    endfunction

    function automatic logic [30:0] lmask(input int w);
        return (31'd1 << w) - 31'd1;
    endfunction

    function automatic logic [30:0] pmod(input logic [30:0] p, input int m);
        logic [30:0] t = p;
        int r = r_of(m);
        for (int i = n_of(m) - 1; i >= r; i--)
            if (t[i]) t = t ^ (31'(gfull(m)) << (i - r));
        return t & lmask(r);
    endfunction

    function automatic logic [30:0] enc_model(input logic [30:0] d, input int m);
        logic [30:0] sh = (d & lmask(n_of(m) - r_of(m))) << r_of(m);
        return sh | pmod(sh, m);
    endfunction

    function automatic logic [30:0] rot(input logic [30:0] w, input int s, input int m);
        logic [30:0] t = w;
        int n = n_of(m);
        for (int i = 0; i < s; i++) t = ((t << 1) | 31'(t[n-1])) & lmask(n);
        return t;
    endfunction

    // Runs one operation; noise drives stray start / code_sel / in_valid while busy
    task automatic run_op(input int m, input bit is_chk, input logic [30:0] word,
                          input int gap, output logic [30:0] got, output int cnt,
                          output logic [10:0] syn, output logic nz);
        int  len = is_chk ? n_of(m) : (n_of(m) - r_of(m));
        int  idx = 0;
        int  guard = 0;
        bit  fin = 0;
        got = '0; cnt = 0; syn = '0; nz = 1'b0;
        @(negedge clk);
        code_sel = 2'(m); check_mode = is_chk; start = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk("R7 busy after start", 32'(busy), 32'd1);
        while (!fin && guard < 400) begin
            if (out_valid) begin
                got = {got[29:0], out_bit};
                cnt++;
            end
            if (done) begin
                fin = 1;
                syn = syndrome;
                nz  = syn_nonzero;
            end
            if (fin) begin
                start = 1'b0; in_valid = 1'b0;
            end else begin
                code_sel   = 2'($urandom);
                check_mode = 1'($urandom);
                start      = ($urandom % 6) == 0;
                if (idx < len) begin
                    in_valid = ($urandom % 100) >= gap;
                    in_bit   = word[len-1-idx];
                    if (in_valid) idx++;
                end else begin
                    in_valid = 1'($urandom);
                    in_bit   = 1'($urandom);
                end
                @(negedge clk);
                guard++;
            end
        end
        @(negedge clk);
        chk("R7 busy low after done", 32'(busy), 32'd0);
    endtask

    task automatic do_enc(input int m, input logic [30:0] d, input int gap,
                          output logic [30:0] cw);
        logic [30:0] got; int cnt; logic [10:0] s; logic z;
        logic [30:0] exp = enc_model(d, m);
        run_op(m, 1'b0, d & lmask(n_of(m) - r_of(m)), gap, got, cnt, s, z);
        chk("R4 encode output length", 32'(cnt), 32'(n_of(m)));
        chk("R3 R4 codeword", 32'(got), 32'(exp));
        cw = got;
    endtask

    task automatic do_chk(input int m, input logic [30:0] w, input int gap,
                          output logic [10:0] s_out);
        logic [30:0] got; int cnt; logic [10:0] s; logic z;
        logic [30:0] exp = pmod(w, m);
        run_op(m, 1'b1, w, gap, got, cnt, s, z);
        chk("R6 syndrome", 32'(s), exp);
        chk("R6 nonzero flag", 32'(z), 32'(exp != 0));
        chk("R6 no output in check", 32'(cnt), 32'd0);
        s_out = s;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [30:0] cw, d, e;
        logic [10:0] s, last_s;
        void'($urandom(32'd4242));
        rst = 1'b1; code_sel = 0; check_mode = 0; start = 0; in_valid = 0; in_bit = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 busy", 32'(busy), 0);
        chk("R9 out_valid", 32'(out_valid), 0);
        chk("R9 done", 32'(done), 0);
        chk("R9 syndrome", 32'(syndrome), 0);
        chk("R9 syn_nonzero", 32'(syn_nonzero), 0);

        // R5: in_valid while idle does nothing
        in_valid = 1'b1; in_bit = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 idle out_valid", 32'(out_valid), 0);
        chk("R5 idle busy", 32'(busy), 0);
        in_valid = 1'b0;

        // R1 / R3 / R4 directed patterns, every code selection
        for (int m = 0; m < 4; m++) begin
            do_enc(m, 31'd0, 0, cw);
            do_enc(m, 31'h7FFFFFFF, 0, cw);
            do_enc(m, 31'd1, 40, cw);
            do_enc(m, 31'(1) << (n_of(m) - r_of(m) - 1), 0, cw);
        end

        // R8: rotations and low-weight errors
        for (int m = 0; m < 3; m++) begin
            do_enc(m, 31'($urandom), 20, cw);
            do_chk(m, cw, 0, s);
            chk("R8 valid word zero syndrome", 32'(s), 0);
            do_chk(m, rot(cw, 1 + m * 3, m), 10, s);
            chk("R8 rotated word zero syndrome", 32'(s), 0);
            do_chk(m, cw ^ 31'(1 << (m + 2)), 0, s);
            chk("R8 single error flagged", 32'(s != 0), 1);
        end
        for (int w = 2; w <= 6; w++) begin
            do_enc(w % 2, 31'($urandom), 0, cw);
            e = '0;
            for (int b = 0; b < w; b++) e[(b * 4 + w) % 23] = 1'b1;
            do_chk(w % 2, cw ^ e, 0, s);
            chk("R8 Golay multi-bit error flagged", 32'(s != 0), 1);
        end

        // R6 hold: encode leaves previous syndrome untouched
        do_chk(0, 31'h155555, 0, last_s);
        do_enc(2, 31'h2AAAAAA, 30, cw);
        chk("R6 syndrome held across encode", 32'(syndrome), 32'(last_s));

        // Random mix, R10 stalls via gaps
        for (int it = 0; it < 40; it++) begin
            int m = int'($urandom % 4);
            d = 31'($urandom);
            do_enc(m, d, int'($urandom % 60), cw);
            e = (($urandom % 3) == 0) ? 31'd0 : (31'($urandom) & lmask(n_of(m)));
            do_chk(m, cw ^ e, int'($urandom % 60), s);
            if (e == 0) chk("R10 stalled valid word", 32'(s), 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule